// File: doc/BRIEF.md
# Fractional-Rate Pulse Width Modulator with Committed Updates

This block drives one pulse-width-modulated output from a single 32-bit control word. The output rate comes from a phase accumulator that adds a programmable step on every clock and wraps modulo 2^BU_W. Each wrap starts a new output cycle, so the output frequency is step × f_clk / 2^BU_W, and the step need not divide 2^BU_W. Duty is set by an 8-bit threshold compared against the top eight accumulator bits. The threshold is stored inverted: a larger value gives a shorter high time.

Software writes the step and the threshold into a shadow copy. A running generator keeps its live settings until software sets the request bit. The shadow copy is then applied at the next accumulator wrap, and at that wrap the request bit clears by itself. While a request is outstanding, writes are dropped. When the generator is stopped, there is no output cycle to wait for, so a request is applied at once.

The control is a three-state machine. STOPPED means the output is disabled and the accumulator is held at zero. RUNNING means the output is enabled and nothing is pending. ARMED means the output is enabled and a request is pending. The transitions are:
- START: STOPPED to RUNNING, on a write with enable set.
- HALT: RUNNING to STOPPED, on a write with enable clear.
- ARM: RUNNING to ARMED, on a write with enable and request set.
- RETUNE: RUNNING to RUNNING, on a write with enable set and request clear.
- COMMIT: ARMED to RUNNING, on an accumulator wrap.
- IDLE_WRITE: STOPPED to STOPPED, on a write with enable clear.

Top module: `frac_pwm`

## Requirements
- R1: After reset, `rd_data` reads 0 and `pwm_out` is low.
- R2: Bit 31 is the enable. While it is 0, `pwm_out` stays low and the accumulator is held at 0, so the next start begins at phase 0.
- R3: Register layout:
  - Bits 7:0 hold the threshold.
  - Bits 8+BU_W-1:8 hold the step.
  - Bit 31 is the enable and bit 30 is the request.
  - All other bits read 0.
  - A read returns the shadow threshold and step together with the live enable and request state.
- R4: While running with no request pending, a write with bit 30 clear updates the shadow fields and the enable only. The live step and threshold, and so the output waveform, do not change.
- R5: While running, a write with bits 31 and 30 set makes a request pending, so bit 30 reads 1. At the next accumulator wrap the shadow fields become live and bit 30 reads 0.
- R6: While a request is pending, every write is ignored: the shadow fields and the enable are unchanged.
- R7: A write with bit 30 set applies its fields at once when the generator is stopped, or when the write clears the enable. After such a write, bit 30 reads 0.
- R8: While enabled, the accumulator adds the live step every clock, modulo 2^BU_W. Over 2^BU_W clocks there are exactly `step` output cycles.
- R9: `pwm_out` is high exactly when the top 8 accumulator bits are strictly greater than the live threshold:
  - A threshold of 255 keeps the output low.
  - A threshold of 0 keeps it low only while the top bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word readback |
| pwm_out | output | 1 | Modulated output |

## Verification
A wrong machine state has two visible effects.
- A stuck ARMED state leaves bit 30 set beyond one output period, and every later write is lost.
- A commit taken before the wrap changes the duty count inside the period in which the request was made.

A corrupted live step or threshold changes the high-cycle count within one output period. A drifting accumulator only shows in the count over a full 2^BU_W-clock window, which is why the fractional case is checked over that whole span.

// File: rtl/frac_pwm_pkg.sv
package frac_pwm_pkg;
    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_RUNNING = 2'd1,
        ST_ARMED   = 2'd2
    } ctl_state_e;

    localparam int unsigned EN_BIT  = 31;
    localparam int unsigned REQ_BIT = 30;
    localparam int unsigned STEP_LO = 8;
    localparam int unsigned THR_W   = 8;
endpackage

// File: rtl/frac_pwm_accum.sv
module frac_pwm_accum #(
    parameter int unsigned BU_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [BU_W-1:0] step,
    output logic [BU_W-1:0] phase,
    output logic            wrap
);
    typedef logic [BU_W-1:0] acc_t;

    logic [BU_W:0] sum;

    assign sum  = {1'b0, phase} + {1'b0, step};
    assign wrap = run & sum[BU_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (run) begin
            phase <= sum[BU_W-1:0];
        end else begin
            phase <= '0;
        end
    end

    // R8: the accumulator advances by the live step every enabled clock
    p_acc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> phase == acc_t'($past(phase) + $past(step)));

    // R2: the accumulator is held at zero while disabled
    p_acc_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> phase == '0);
endmodule

// File: rtl/frac_pwm_cmp.sv
module frac_pwm_cmp #(
    parameter int unsigned BU_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [BU_W-1:0] phase,
    input  logic [7:0]      thr,
    output logic            pwm_o
);
    localparam int unsigned TOP_LO = BU_W - 8;

    logic [7:0] top8;
    logic [TOP_LO-1:0] unused_low;

    assign top8       = phase[BU_W-1:TOP_LO];
    assign unused_low = phase[TOP_LO-1:0];

    always_comb begin
        pwm_o = run && (top8 > thr);
    end

    // R2: disabled output is low
    p_off_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm_o);

    // R9: a threshold of 255 never produces a high output
    p_thr_max_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == 8'hFF) |-> !pwm_o);
endmodule

// File: rtl/frac_pwm_ctl.sv
module frac_pwm_ctl
    import frac_pwm_pkg::*;
#(
    parameter int unsigned BU_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_en_bit,
    input  logic            wr_req_bit,
    input  logic [BU_W-1:0] wr_step,
    input  logic [7:0]      wr_thr,
    input  logic            wrap,
    output logic            run,
    output logic            pending,
    output logic [BU_W-1:0] shadow_step,
    output logic [7:0]      shadow_thr,
    output logic [BU_W-1:0] live_step,
    output logic [7:0]      live_thr
);
    ctl_state_e state_q, state_d;
    logic accept;
    logic load_now;
    logic load_wrap;

    always_comb begin
        accept    = wr_en && (state_q != ST_ARMED);
        load_now  = accept && wr_req_bit && ((state_q == ST_STOPPED) || !wr_en_bit);
        load_wrap = (state_q == ST_ARMED) && wrap;
        state_d   = state_q;
        unique case (state_q)
            ST_STOPPED: begin
                if (accept && wr_en_bit) state_d = ST_RUNNING;      // START
            end
            ST_RUNNING: begin
                if (accept) begin
                    if (!wr_en_bit)      state_d = ST_STOPPED;      // HALT
                    else if (wr_req_bit) state_d = ST_ARMED;        // ARM
                    else                 state_d = ST_RUNNING;      // RETUNE
                end
            end
            ST_ARMED: begin
                if (wrap) state_d = ST_RUNNING;                     // COMMIT
            end
            default: state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_step <= '0;
            shadow_thr  <= '0;
            live_step   <= '0;
            live_thr    <= '0;
        end else begin
            if (accept) begin
                shadow_step <= wr_step;
                shadow_thr  <= wr_thr;
            end
            if (load_now) begin
                live_step <= wr_step;
                live_thr  <= wr_thr;
            end else if (load_wrap) begin
                live_step <= shadow_step;
                live_thr  <= shadow_thr;
            end
        end
    end

    always_comb begin
        run     = (state_q != ST_STOPPED);
        pending = (state_q == ST_ARMED);
    end

    // R5: a pending request is applied and cleared at the wrap
    p_commit_at_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && wrap) |=> (!pending && live_thr == $past(shadow_thr)
                               && live_step == $past(shadow_step)));

    // R6: writes during a pending request are dropped
    p_drop_while_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !wrap) |=> ($stable(shadow_thr) && $stable(shadow_step) && pending));

    // R4: a plain write while running leaves live settings untouched
    p_live_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !pending && wr_en && wr_en_bit && !wr_req_bit) |=>
            ($stable(live_thr) && $stable(live_step)));

    // R7: an immediate request never leaves the request bit set
    p_stop_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && wr_en && wr_req_bit) |=> (!pending && live_thr == $past(wr_thr)));
endmodule

// File: rtl/frac_pwm.sv
module frac_pwm
    import frac_pwm_pkg::*;
#(
    parameter int unsigned BU_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pwm_out
);
    localparam int unsigned STEP_HI = STEP_LO + BU_W - 1;
    localparam logic [31:0] USED_MASK =
        (32'h1 << EN_BIT) | (32'h1 << REQ_BIT) |
        (((32'h1 << BU_W) - 32'h1) << STEP_LO) | 32'h0000_00FF;

    logic            run;
    logic            pending;
    logic            wrap;
    logic [BU_W-1:0] phase;
    logic [BU_W-1:0] shadow_step;
    logic [BU_W-1:0] live_step;
    logic [7:0]      shadow_thr;
    logic [7:0]      live_thr;
    logic            unused_hi;

    assign unused_hi = ^(wr_data & ~USED_MASK);

    frac_pwm_ctl #(.BU_W(BU_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_en_bit  (wr_data[EN_BIT]),
        .wr_req_bit (wr_data[REQ_BIT]),
        .wr_step    (wr_data[STEP_HI:STEP_LO]),
        .wr_thr     (wr_data[THR_W-1:0]),
        .wrap       (wrap),
        .run        (run),
        .pending    (pending),
        .shadow_step(shadow_step),
        .shadow_thr (shadow_thr),
        .live_step  (live_step),
        .live_thr   (live_thr)
    );

    frac_pwm_accum #(.BU_W(BU_W)) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .step (live_step),
        .phase(phase),
        .wrap (wrap)
    );

    frac_pwm_cmp #(.BU_W(BU_W)) u_cmp (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .phase(phase),
        .thr  (live_thr),
        .pwm_o(pwm_out)
    );

    always_comb begin
        rd_data                   = '0;
        rd_data[EN_BIT]           = run;
        rd_data[REQ_BIT]          = pending;
        rd_data[STEP_HI:STEP_LO]  = shadow_step;
        rd_data[THR_W-1:0]        = shadow_thr;
    end

    // R1: reset leaves the output low and the readback clear
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 32'h0 && !pwm_out));
endmodule

// File: tb/tb_frac_pwm.sv
module tb_frac_pwm;
    localparam int BU_W = 16;
    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        int    len;
        int    exp;
        string tag;
    } win_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    win_t sb_q[$];

    frac_pwm #(.BU_W(BU_W)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] word(bit en, bit req, int step, int thr);
        logic [31:0] w = '0;
        w[31] = en;
        w[30] = req;
        w[8 +: BU_W] = step[BU_W-1:0];
        w[7:0] = thr[7:0];
        return w;
    endfunction

    // Expected high cycles: top 8 bits of (k*step mod 2^BU_W) above threshold
    function automatic int exp_high(int step, int thr, int len);
        int cnt = 0;
        for (int k = 0; k < len; k++) begin
            longint a = (longint'(k) * step) % (longint'(1) << BU_W);
            if ((a >> (BU_W - 8)) > thr) cnt++;
        end
        return cnt;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic wait_commit(string tag);
        int n = 0;
        while (rd_data[30] && n < 70000) begin
            @(negedge clk);
            n++;
        end
        check(rd_data[30] == 1'b0, tag, rd_data[30], 0);
    endtask

    task automatic expect_window(int len, int exp, string tag);
        win_t w;
        w.len = len;
        w.exp = exp;
        w.tag = tag;
        sb_q.push_back(w);
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: counts high cycles over each queued window
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                win_t w = sb_q[0];
                int cnt = 0;
                for (int i = 0; i < w.len; i++) begin
                    if (pwm_out) cnt++;
                    if (i != w.len - 1) @(negedge clk);
                end
                check(cnt == w.exp, w.tag, cnt, w.exp);
                void'(sb_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rd_data == 32'h0, "R1 reset readback", rd_data, 0);
        check(pwm_out == 1'b0, "R1 reset output", pwm_out, 0);
        rst_n = 1'b1;

        // R7: start with request while stopped applies at once
        reg_write(word(1, 1, 4096, 0));
        check(rd_data == word(1, 0, 4096, 0), "R7 start readback", rd_data, word(1, 0, 4096, 0));
        // R3: field layout in readback
        check(rd_data[23:8] == 16'd4096 && rd_data[29:24] == 0, "R3 step field", rd_data, word(1, 0, 4096, 0));
        // R8/R9: period 16, threshold 0 -> 15 of 16 high
        expect_window(16, exp_high(4096, 0, 16), "R9 thr0 duty");
        check(exp_high(4096, 0, 16) == 15, "R9 model thr0", exp_high(4096, 0, 16), 15);

        // R4: plain write changes shadow only
        reg_write(word(1, 0, 4096, 200));
        check(rd_data[7:0] == 8'd200, "R4 shadow updated", rd_data[7:0], 200);
        expect_window(16, 15, "R4 live unchanged");

        // R5: request applies at wrap, bit clears
        reg_write(word(1, 1, 4096, 128));
        check(rd_data[30] == 1'b1, "R5 request pending", rd_data[30], 1);
        wait_commit("R5 request cleared");
        expect_window(16, 7, "R5 thr128 duty");

        // R9: threshold 255 always low
        reg_write(word(1, 1, 4096, 255));
        wait_commit("R5 clear thr255");
        expect_window(32, 0, "R9 thr255 low");

        // R6: writes during pending are dropped
        reg_write(word(0, 0, 4096, 0));
        reg_write(word(1, 1, 4096, 0));
        reg_write(word(1, 1, 4096, 64));
        reg_write(word(1, 0, 4096, 200));
        check(rd_data[7:0] == 8'd64 && rd_data[30], "R6 dropped write", rd_data, word(1, 1, 4096, 64));
        wait_commit("R6 commit after drop");
        expect_window(16, 11, "R6 thr64 duty");

        // R8: step 8192 -> period 8
        reg_write(word(1, 1, 8192, 0));
        wait_commit("R8 clear step8192");
        expect_window(8, exp_high(8192, 0, 8), "R8 step8192 duty");

        // R2: disable holds output low
        reg_write(word(0, 0, 8192, 0));
        check(rd_data[31] == 1'b0, "R2 enable clear", rd_data[31], 0);
        expect_window(40, 0, "R2 disabled low");

        // R7: request with enable clear applies at once
        reg_write(word(0, 1, 3000, 100));
        check(rd_data == word(0, 0, 3000, 100), "R7 stopped commit", rd_data, word(0, 0, 3000, 100));

        // R8: fractional step over a full accumulator span
        reg_write(word(1, 0, 3000, 100));
        expect_window(1 << BU_W, exp_high(3000, 100, 1 << BU_W), "R8 fractional span");

        finish_run();
    end
endmodule